// File: doc/BRIEF.md
# DRAM Bank Column Burst Engine

This block is a synthesizable behavioural model of the device side of one synchronous DRAM bank. A controller drives one command per clock together with a row address, a column address and write data. An open command copies one row of the storage array into a row buffer. Column reads and writes are then served from that buffer until a close command writes the buffer back and leaves the bank with no open row.

Each column command starts a burst. An internal counter walks the column address through an aligned block whose size is the programmed burst length, so one command moves 1, 2, 4 or 8 words on consecutive cycles. Read words leave a fixed number of cycles after the command, set by the programmed CAS latency. Write words are taken from the data input a separate, programmed write latency after the command. The mode is written once, in an initialization phase after reset, before any other command is accepted.

Top module: `dram_bank_burst`

## Requirements
- R1: After reset `ready_o`, `rvalid_o` and `err_o` are low, `rdata_o` is zero, and every word of every row reads as zero.
- R2: Until a mode command (code 1) arrives, all other commands are ignored with no error and no data. A mode command raises `ready_o` in the next cycle. Mode commands after that are ignored and leave the latencies unchanged.
- R3: The mode command takes its fields from `wdata_i`: bits [4:0] read latency, bits [9:5] write latency, bits [11:10] burst code (0, 1, 2, 3 select 1, 2, 4, 8 words). A latency field below 2 is taken as 2, above 16 as 16.
- R4: For a read command (code 3) in cycle k with a row open, `rvalid_o` is high in cycles k+CL to k+CL+BL-1 and carries burst words in order. `rdata_o` is zero whenever `rvalid_o` is low.
- R5: Burst word i of a command at column c uses column (c with its low log2(BL) bits cleared) plus ((c+i) mod BL), so the burst wraps inside its aligned block.
- R6: For a write command (code 4) in cycle k with a row open, burst word i is taken from `wdata_i` in cycle k+WL+i. `wdata_i` in any other cycle is not stored.
- R7: Column commands can follow one another on an open row without a new open command. A column command that arrives while an earlier burst is still being stepped ends that burst and starts its own, so words already stepped still come out.
- R8: An open command (code 2, row from `row_i`) loads the row only when no row is open; an open command while a row is open is ignored. A close command (code 5) stores the buffer back into its row and closes it, so data persists across close and reopen.
- R9: A read or write command after initialization while no row is open raises `err_o` for exactly the next cycle. It is otherwise ignored: no data comes out and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command: 0 none, 1 mode, 2 open, 3 read, 4 write, 5 close |
| row_i | input | ROW_W | Row address for an open command |
| col_i | input | COL_W | Start column for read and write commands |
| wdata_i | input | DATA_W | Write data; mode value for a mode command |
| rdata_o | output | DATA_W | Read burst data |
| rvalid_o | output | 1 | High on exactly the cycles carrying read data |
| err_o | output | 1 | One-cycle pulse for a column command with no open row |
| ready_o | output | 1 | Initialization done |

## Verification
The bench builds the block with four rows of eight columns, so every start column within a row, and the wrap inside every burst block, is covered for each burst length. It resets the block and runs a full write and read pass for each of 24 mode settings. These settings pair every burst length with read latencies of 0, 2, 3, 7, 16 and 25 and with write latencies from 1 to 31, so both clamp limits and the deepest delay-line taps are reached. Directed runs then cover commands sent before initialization, a repeated mode command, a column command with no open row, a read that cuts short an earlier burst, and data kept across close and reopen.

// File: rtl/dbb_pkg.sv
`timescale 1ns/1ps
package dbb_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_MODE  = 3'd1,
        CMD_OPEN  = 3'd2,
        CMD_READ  = 3'd3,
        CMD_WRITE = 3'd4,
        CMD_CLOSE = 3'd5
    } cmd_e;

    localparam int LAT_W   = 5;
    localparam int MIN_LAT = 2;
    localparam int MAX_LAT = 16;

    // mode value layout on the write data bus
    localparam int CL_LSB = 0;
    localparam int WL_LSB = 5;
    localparam int BL_LSB = 10;
    localparam int MODE_W = 12;

    function automatic logic [LAT_W-1:0] clamp_lat(input logic [LAT_W-1:0] raw);
        if (raw < LAT_W'(MIN_LAT)) return LAT_W'(MIN_LAT);
        if (raw > LAT_W'(MAX_LAT)) return LAT_W'(MAX_LAT);
        return raw;
    endfunction

endpackage

// File: rtl/dbb_mode_reg.sv
`timescale 1ns/1ps
module dbb_mode_reg
    import dbb_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [MODE_W-1:0] value_i,
    output logic [LAT_W-1:0]  cl_o,
    output logic [LAT_W-1:0]  wl_o,
    output logic [1:0]        bl_code_o,
    output logic              ready_o
);

    typedef struct packed {
        logic             ready;
        logic [LAT_W-1:0] cl;
        logic [LAT_W-1:0] wl;
        logic [1:0]       bl;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (load_i && !mode_q.ready) begin
            mode_d.ready = 1'b1;
            mode_d.cl    = clamp_lat(value_i[CL_LSB +: LAT_W]);
            mode_d.wl    = clamp_lat(value_i[WL_LSB +: LAT_W]);
            mode_d.bl    = value_i[BL_LSB +: 2];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q.ready <= 1'b0;
            mode_q.cl    <= LAT_W'(MIN_LAT);
            mode_q.wl    <= LAT_W'(MIN_LAT);
            mode_q.bl    <= 2'd0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign cl_o      = mode_q.cl;
    assign wl_o      = mode_q.wl;
    assign bl_code_o = mode_q.bl;
    assign ready_o   = mode_q.ready;

    assert_cl_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_q.ready |-> (mode_q.cl >= LAT_W'(MIN_LAT) && mode_q.cl <= LAT_W'(MAX_LAT)
                          && mode_q.wl >= LAT_W'(MIN_LAT) && mode_q.wl <= LAT_W'(MAX_LAT)));

    assert_mode_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_q.ready |=> ($stable(mode_q.cl) && $stable(mode_q.wl) && $stable(mode_q.bl)));

endmodule

// File: rtl/dbb_burst_gen.sv
`timescale 1ns/1ps
module dbb_burst_gen #(
    parameter int COL_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             start_wr_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             kill_i,
    input  logic [1:0]       bl_code_i,
    output logic             issue_o,
    output logic             issue_wr_o,
    output logic [COL_W-1:0] issue_col_o
);

    localparam int IDX_W = 3;

    typedef struct packed {
        logic             active;
        logic             wr;
        logic [COL_W-1:0] base;
        logic [IDX_W-1:0] idx;
    } burst_t;

    burst_t bst_d, bst_q;

    logic [3:0]       len_m1;
    logic [COL_W-1:0] blk_mask;
    logic             last_word;

    assign len_m1    = (4'd1 << bl_code_i) - 4'd1;
    assign blk_mask  = COL_W'(len_m1);
    assign last_word = (bst_q.idx == len_m1[IDX_W-1:0]);

    always_comb begin
        bst_d = bst_q;
        if (kill_i) begin
            bst_d.active = 1'b0;
        end else if (start_i) begin
            bst_d.active = 1'b1;
            bst_d.wr     = start_wr_i;
            bst_d.base   = start_col_i;
            bst_d.idx    = '0;
        end else if (bst_q.active) begin
            if (last_word) bst_d.active = 1'b0;
            else           bst_d.idx    = bst_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) bst_q <= '0;
        else         bst_q <= bst_d;
    end

    assign issue_o     = bst_q.active;
    assign issue_wr_o  = bst_q.wr;
    assign issue_col_o = (bst_q.base & ~blk_mask)
                       | ((bst_q.base + COL_W'(bst_q.idx)) & blk_mask);

    assert_idx_in_burst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bst_q.active |-> ({1'b0, bst_q.idx} <= len_m1));

endmodule

// File: rtl/dbb_lat_line.sv
`timescale 1ns/1ps
module dbb_lat_line #(
    parameter int DEPTH = 15,
    parameter int PW    = 16,
    parameter int TAP_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             in_valid_i,
    input  logic [PW-1:0]    in_payload_i,
    input  logic [TAP_W-1:0] tap_i,
    output logic             out_valid_o,
    output logic [PW-1:0]    out_payload_o
);

    typedef struct packed {
        logic [DEPTH-1:0]         v;
        logic [DEPTH-1:0][PW-1:0] p;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d.v = {1'b0, line_q.v[DEPTH-1:1]};
        line_d.p = {{PW{1'b0}}, line_q.p[DEPTH-1:1]};
        if (in_valid_i) begin
            line_d.v[tap_i] = 1'b1;
            line_d.p[tap_i] = in_payload_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) line_q <= '0;
        else         line_q <= line_d;
    end

    assign out_valid_o   = line_q.v[0];
    assign out_payload_o = line_q.p[0];

    logic above_busy;
    assign above_busy = (tap_i < TAP_W'(DEPTH - 1)) ? line_q.v[TAP_W'(tap_i + TAP_W'(1))] : 1'b0;

    assert_no_collide_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |-> !above_busy);

endmodule

// File: rtl/dram_bank_burst.sv
`timescale 1ns/1ps
module dram_bank_burst
    import dbb_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        cmd_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              err_o,
    output logic              ready_o
);

    localparam int NUM_ROWS   = 1 << ROW_W;
    localparam int NUM_COLS   = 1 << COL_W;
    localparam int NUM_WORDS  = NUM_ROWS * NUM_COLS;
    localparam int LINE_DEPTH = MAX_LAT - 1;
    localparam int TAP_W      = $clog2(LINE_DEPTH);

    typedef struct packed {
        logic             row_open;
        logic [ROW_W-1:0] open_row;
        logic             err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [DATA_W-1:0] mem_d  [NUM_WORDS];
    logic [DATA_W-1:0] mem_q  [NUM_WORDS];
    logic [DATA_W-1:0] rbuf_d [NUM_COLS];
    logic [DATA_W-1:0] rbuf_q [NUM_COLS];

    logic             ready;
    logic [LAT_W-1:0] cl, wl;
    logic [1:0]       bl_code;

    dbb_mode_reg u_mode (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (cmd_i == CMD_MODE),
        .value_i   (wdata_i[MODE_W-1:0]),
        .cl_o      (cl),
        .wl_o      (wl),
        .bl_code_o (bl_code),
        .ready_o   (ready)
    );

    logic is_col, col_ok, close_ok;
    assign is_col   = (cmd_i == CMD_READ) || (cmd_i == CMD_WRITE);
    assign col_ok   = ready && is_col && ctl_q.row_open;
    assign close_ok = ready && (cmd_i == CMD_CLOSE) && ctl_q.row_open;

    logic             issue, issue_wr;
    logic [COL_W-1:0] issue_col;

    dbb_burst_gen #(.COL_W(COL_W)) u_burst (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (col_ok),
        .start_wr_i  (cmd_i == CMD_WRITE),
        .start_col_i (col_i),
        .kill_i      (close_ok),
        .bl_code_i   (bl_code),
        .issue_o     (issue),
        .issue_wr_o  (issue_wr),
        .issue_col_o (issue_col)
    );

    logic [TAP_W-1:0] rd_tap, wr_tap;
    assign rd_tap = TAP_W'(cl - LAT_W'(MIN_LAT));
    assign wr_tap = TAP_W'(wl - LAT_W'(MIN_LAT));

    dbb_lat_line #(.DEPTH(LINE_DEPTH), .PW(DATA_W), .TAP_W(TAP_W)) u_rd_line (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .in_valid_i    (issue && !issue_wr),
        .in_payload_i  (rbuf_q[issue_col]),
        .tap_i         (rd_tap),
        .out_valid_o   (rvalid_o),
        .out_payload_o (rdata_o)
    );

    logic             wr_due;
    logic [COL_W-1:0] wr_col;

    dbb_lat_line #(.DEPTH(LINE_DEPTH), .PW(COL_W), .TAP_W(TAP_W)) u_wr_line (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .in_valid_i    (issue && issue_wr),
        .in_payload_i  (issue_col),
        .tap_i         (wr_tap),
        .out_valid_o   (wr_due),
        .out_payload_o (wr_col)
    );

    always_comb begin
        ctl_d     = ctl_q;
        mem_d     = mem_q;
        rbuf_d    = rbuf_q;
        ctl_d.err = ready && is_col && !ctl_q.row_open;

        // delayed write capture into the open row
        if (wr_due && ctl_q.row_open) rbuf_d[wr_col] = wdata_i;

        if (ready && cmd_i == CMD_OPEN && !ctl_q.row_open) begin
            ctl_d.row_open = 1'b1;
            ctl_d.open_row = row_i;
            for (int c = 0; c < NUM_COLS; c++)
                rbuf_d[c] = mem_q[{row_i, COL_W'(c)}];
        end

        if (close_ok) begin
            ctl_d.row_open = 1'b0;
            for (int c = 0; c < NUM_COLS; c++)
                mem_d[{ctl_q.open_row, COL_W'(c)}] = rbuf_d[c];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q <= '0;
            for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= '0;
            for (int c = 0; c < NUM_COLS; c++)  rbuf_q[c] <= '0;
        end else begin
            ctl_q  <= ctl_d;
            mem_q  <= mem_d;
            rbuf_q <= rbuf_d;
        end
    end

    assign err_o   = ctl_q.err;
    assign ready_o = ready;

    assert_quiet_before_init_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_o |-> (!rvalid_o && !err_o));

    assert_err_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> $past(cmd_i == CMD_READ || cmd_i == CMD_WRITE));

endmodule

// File: tb/dram_bank_burst_tb_top.sv
`timescale 1ns/1ps
module dram_bank_burst_tb_top;
    import dbb_pkg::*;

    localparam int ROW_W = 2;
    localparam int COL_W = 3;
    localparam int DW    = 16;
    localparam int NR    = 4;
    localparam int NC    = 8;
    localparam int RING  = 4096;
    localparam logic [15:0] JUNK = 16'hBAD0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cmd = 3'd0;
    logic [ROW_W-1:0] row = '0;
    logic [COL_W-1:0] col = '0;
    logic [DW-1:0] wdata = JUNK;
    logic [DW-1:0] rdata_o;
    logic          rvalid_o, err_o, ready_o;

    always #2.5 clk = ~clk;

    dram_bank_burst #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .row_i(row), .col_i(col),
        .wdata_i(wdata), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
        .err_o(err_o), .ready_o(ready_o)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;

    logic          expv   [RING];
    logic [DW-1:0] expd   [RING];
    logic          experr [RING];

    logic [DW-1:0] mem [NR][NC];
    bit row_is_open;
    int cur_row, cl_e, wl_e, bl_e;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // cycle monitor: R4 R5 R6 R7 R9 compare against the arithmetic schedule
    always @(negedge clk) begin
        if (mon_en) begin
            int ix;
            ix = cyc % RING;
            chk(rvalid_o === expv[ix], "R4 rvalid", int'(rvalid_o), int'(expv[ix]));
            chk(rdata_o === (expv[ix] ? expd[ix] : 16'h0), "R5 rdata", int'(rdata_o),
                int'(expv[ix] ? expd[ix] : 16'h0));
            chk(err_o === experr[ix], "R9 err", int'(err_o), int'(experr[ix]));
            expv[ix] = 1'b0; expd[ix] = '0; experr[ix] = 1'b0;
        end
    end

    function automatic int seq(input int c, input int i, input int bl);
        return ((c & ~(bl - 1)) | ((c + i) & (bl - 1))) & (NC - 1);
    endfunction

    function automatic int clampv(input int v);
        return (v < 2) ? 2 : ((v > 16) ? 16 : v);
    endfunction

    function automatic logic [DW-1:0] wval(input int base, input int c);
        return 16'(base ^ (c * 16'h0111));
    endfunction

    task automatic drive(input logic [2:0] cv, input int r, input int c, input logic [DW-1:0] wd);
        cmd = cv; row = ROW_W'(r); col = COL_W'(c); wdata = wd;
        @(negedge clk);
        cmd = CMD_NOP; wdata = JUNK;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        mon_en = 1'b0;
        rst_n = 1'b0;
        cmd = CMD_NOP; wdata = JUNK;
        idle(3);
        for (int i = 0; i < RING; i++) begin expv[i] = 0; expd[i] = '0; experr[i] = 0; end
        for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) mem[r][c] = '0;
        row_is_open = 0;
        rst_n = 1'b1;
        idle(1);
        // R1 reset state at the ports
        chk(!ready_o && !rvalid_o && !err_o && rdata_o == 0, "R1 reset outputs",
            {ready_o, rvalid_o, err_o}, 0);
        mon_en = 1'b1;
    endtask

    task automatic mode_set(input int rcl, input int rwl, input int blc);
        drive(CMD_MODE, 0, 0, {4'b0, 2'(blc), 5'(rwl), 5'(rcl)});
        chk(ready_o == 1'b1, "R2 ready after mode", int'(ready_o), 1);
        cl_e = clampv(rcl); wl_e = clampv(rwl); bl_e = 1 << blc;
    endtask

    task automatic rd(input int c);
        int k;
        k = cyc;
        if (row_is_open) begin
            for (int i = 0; i < bl_e; i++) begin
                expv[(k + cl_e + i) % RING] = 1'b1;
                expd[(k + cl_e + i) % RING] = mem[cur_row][seq(c, i, bl_e)];
            end
        end else begin
            experr[(k + 1) % RING] = 1'b1;
        end
        drive(CMD_READ, 0, c, JUNK);
    endtask

    task automatic wr(input int c, input int base);
        int k;
        k = cyc;
        if (!row_is_open) experr[(k + 1) % RING] = 1'b1;
        drive(CMD_WRITE, 0, c, JUNK);
        for (int j = 1; j < wl_e + bl_e; j++) begin
            if (j >= wl_e) begin
                int cc;
                cc = seq(c, j - wl_e, bl_e);
                wdata = wval(base, cc);
                if (row_is_open) mem[cur_row][cc] = wval(base, cc);
            end else begin
                wdata = JUNK ^ 16'(j);
            end
            @(negedge clk);
        end
        wdata = JUNK;
    endtask

    task automatic open_r(input int r);
        drive(CMD_OPEN, r, 0, JUNK);
        if (!row_is_open) begin row_is_open = 1; cur_row = r; end
    endtask

    task automatic close_r();
        drive(CMD_CLOSE, 0, 0, JUNK);
        row_is_open = 0;
    endtask

    task automatic read_page();
        for (int c = 0; c < NC; c++) begin
            rd(c);
            idle(bl_e - 1);   // R7 back-to-back bursts with no gap
        end
        idle(cl_e + bl_e + 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int rcl_tab [6] = '{0, 2, 3, 7, 16, 25};
        int rwl_tab [6] = '{31, 16, 2, 5, 1, 9};

        // R1 R2: commands before initialization have no effect
        do_reset();
        drive(CMD_READ, 0, 0, JUNK);
        drive(CMD_OPEN, 1, 0, JUNK);
        drive(CMD_WRITE, 0, 0, JUNK);
        idle(20);
        chk(ready_o == 1'b0, "R2 not ready before mode", int'(ready_o), 0);
        mode_set(3, 4, 2);
        // R9: the earlier open was ignored, so no row is open now
        rd(0);
        idle(10);
        wr(2, 16'h5A5A);
        idle(5);
        open_r(0);
        read_page();            // R1 zero contents, R9 write dropped
        // R2: a second mode command changes nothing
        drive(CMD_MODE, 0, 0, {4'b0, 2'd3, 5'd9, 5'd9});
        wr(5, 16'h1234);
        read_page();
        close_r();
        idle(4);

        // R3 R4 R5 R6 R7: sweep of burst lengths and latencies
        for (int blc = 0; blc < 4; blc++) begin
            for (int ci = 0; ci < 6; ci++) begin
                int cfg, bl;
                cfg = blc * 6 + ci;
                do_reset();
                mode_set(rcl_tab[ci], rwl_tab[ci], blc);
                open_r(cfg % NR);
                bl = 1 << blc;
                for (int b = 0; b < NC / bl; b++)
                    wr(b * bl + (b % bl), 16'(cfg * 16'h0101 + 1));
                read_page();
                close_r();
            end
        end

        // R7: a read cuts short the burst still being stepped
        do_reset();
        mode_set(3, 2, 3);
        open_r(1);
        wr(0, 16'h4400);
        rd(0);
        idle(1);
        rd(4);
        idle(20);

        // R8: close stores the row, an open while open is ignored
        close_r();
        open_r(2);
        wr(3, 16'h7700);
        open_r(3);
        read_page();
        close_r();
        open_r(1);
        read_page();
        close_r();
        open_r(2);
        read_page();
        close_r();
        idle(4);

        done = 1'b1;
        mon_en = 1'b0;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule